// File: doc/BRIEF.md
# Retriggerable Resettable Pulse Generator

This block produces one output pulse of a programmed number of clock cycles each time it sees a qualifying trigger edge. It stands in for an analog one-shot: instead of a resistor and capacitor, the pulse length comes from a cycle count presented on `width_i`, which is captured when a trigger is accepted. Two trigger inputs give a choice of edge: a rising edge on `trig_a_i` counts while `trig_b_i` is high, and a falling edge on `trig_b_i` counts while `trig_a_i` is low. Tie the unused input to its enabling level to get a pure rising-edge or pure falling-edge one-shot.

A trigger that arrives during a pulse reloads the full count, so the output stays high until one whole width has passed after the last accepted edge. An active-low level clear (`clr_n_i`) ends any pulse at once and blocks all triggers while it is held low. The three control inputs are asynchronous and pass through synchronizer stages inside the block. A one-cycle `pulse_done_o` strobe marks a pulse that ran out on its own. For two channels, instantiate the block twice.

Top module: `trig_pulse_gen`

## Requirements
- R1: With `clr_n_i` high, a low-to-high change of `trig_a_i` while `trig_b_i` is high is a trigger; `pulse_o` goes high on the third rising clock edge after the input changes (two synchronizer stages, then the output register), regardless of the programmed width.
- R2: With `clr_n_i` high, a high-to-low change of `trig_b_i` while `trig_a_i` is low is a trigger, with the same three-edge latency as R1.
- R3: During and after `rst_n` low, with no trigger, `pulse_o` is 0, `pulse_n_o` is 1 and `pulse_done_o` is 0.
- R4: Once triggered, `pulse_o` stays high for exactly N clock cycles, where N is the unsigned value of `width_i` at acceptance (1 to 2^WIDTH-1); a qualifying edge seen while `width_i` is 0 starts nothing.
- R5: A trigger accepted while `pulse_o` is high reloads the count, so `pulse_o` stays high without a gap until N cycles after the last accepted trigger.
- R6: When `clr_n_i` goes low, `pulse_o` returns to 0 and `pulse_n_o` to 1 on the third rising clock edge after the change, even mid-pulse.
- R7: While `clr_n_i` is held low, edges on `trig_a_i` and `trig_b_i` are ignored and the outputs stay idle.
- R8: A rising edge on `trig_a_i` while `trig_b_i` is low, a falling edge on `trig_b_i` while `trig_a_i` is high, a falling edge on `trig_a_i` and a rising edge on `trig_b_i` are not triggers and leave the outputs unchanged.
- R9: `pulse_done_o` is high for exactly one cycle, the first cycle in which `pulse_o` is low after a pulse that ended by its count running out; it stays low when a pulse is ended by `clr_n_i`.
- R10: `pulse_n_o` is always the complement of `pulse_o`.
- R11: A qualifying edge that occurs while `clr_n_i` is low is not remembered: releasing the clear alone starts no pulse, and only a fresh qualifying edge afterwards does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of all flops |
| trig_a_i | input | 1 | Trigger input, rising edge active while `trig_b_i` is high (asynchronous) |
| trig_b_i | input | 1 | Trigger input, falling edge active while `trig_a_i` is low (asynchronous) |
| clr_n_i | input | 1 | Active-low level clear: ends the pulse and blocks triggers (asynchronous) |
| width_i | input | WIDTH | Pulse length in clock cycles, captured at trigger acceptance |
| pulse_o | output | 1 | Pulse output, high while timing |
| pulse_n_o | output | 1 | Complement of `pulse_o` |
| pulse_done_o | output | 1 | One-cycle strobe when a pulse ends by timeout |

## Verification
The assertions relate `clr_n_i` to the outputs through a fixed three-edge delay, so they take for granted that the clear input is sampled cleanly by the first synchronizer flop and that no metastable extra cycle appears; they also take `width_i` as steady while an edge travels through the synchronizers. The stimulus changes every input only on the falling clock edge and holds `width_i` constant from before each trigger until the pulse is accepted, so the sampled values are unambiguous. Pulse lengths are measured by counting high cycles at the ports, including a retrigger midway through a pulse, the single-cycle width, the largest width and a zero width.

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_a_i,
  input  logic             trig_b_i,
  input  logic             clr_n_i,
  input  logic [WIDTH-1:0] width_i,
  output logic             pulse_o,
  output logic             pulse_n_o,
  output logic             pulse_done_o
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0]     a_sh, b_sh, c_sh;
  logic             a_last, b_last;
  logic [WIDTH-1:0] remain;
  logic             a_now, b_now, clr_ok;
  logic             a_rise_ok, b_fall_ok, fire, expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sh   <= '0;
      b_sh   <= '0;
      c_sh   <= '0;
      a_last <= 1'b0;
      b_last <= 1'b0;
    end else begin
      a_sh   <= {a_sh[TOP-1:0], trig_a_i};
      b_sh   <= {b_sh[TOP-1:0], trig_b_i};
      c_sh   <= {c_sh[TOP-1:0], clr_n_i};
      a_last <= a_now;
      b_last <= b_now;
    end
  end

  assign a_now  = a_sh[TOP];
  assign b_now  = b_sh[TOP];
  assign clr_ok = c_sh[TOP];

  assign a_rise_ok = a_now && !a_last && b_now;
  assign b_fall_ok = !b_now && b_last && !a_now;
  assign fire      = clr_ok && (width_i != '0) && (a_rise_ok || b_fall_ok);
  assign expire    = pulse_o && (remain == WIDTH'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_o      <= 1'b0;
      pulse_n_o    <= 1'b1;
      pulse_done_o <= 1'b0;
      remain       <= '0;
    end else begin
      pulse_done_o <= 1'b0;
      if (!clr_ok) begin
        pulse_o   <= 1'b0;
        pulse_n_o <= 1'b1;
        remain    <= '0;
      end else if (fire) begin
        pulse_o   <= 1'b1;
        pulse_n_o <= 1'b0;
        remain    <= width_i;
      end else if (expire) begin
        pulse_o      <= 1'b0;
        pulse_n_o    <= 1'b1;
        pulse_done_o <= 1'b1;
        remain       <= '0;
      end else if (pulse_o) begin
        remain <= remain - WIDTH'(1);
      end
    end
  end

endmodule

// File: rtl/trig_pulse_gen_chk.sv
module trig_pulse_gen_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic clr_n_i,
  input logic pulse_o,
  input logic pulse_n_o,
  input logic pulse_done_o
);

  localparam int LAT = SYNC_STAGES + 1;

  // R9
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_done_o |-> ($past(pulse_o) && !pulse_o));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_done_o |=> !pulse_done_o);

  // R6
  clear_forces_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_n_i, LAT) |-> !pulse_o);

  // R9
  no_done_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_n_i, LAT) |-> !pulse_done_o);

  // R10
  complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_n_o == !pulse_o);

endmodule

bind trig_pulse_gen trig_pulse_gen_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clr_n_i      (clr_n_i),
  .pulse_o      (pulse_o),
  .pulse_n_o    (pulse_n_o),
  .pulse_done_o (pulse_done_o)
);

// File: tb/trig_pulse_gen_bench.sv
module trig_pulse_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       a, b, clr_n;
  logic [7:0] w;
  logic       pulse, pulse_n, done;

  int checks = 0;
  int errors = 0;
  int hi;

  always #10 clk = ~clk;

  trig_pulse_gen #(.WIDTH(8), .SYNC_STAGES(2)) u_trig_pulse_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_a_i     (a),
    .trig_b_i     (b),
    .clr_n_i      (clr_n),
    .width_i      (w),
    .pulse_o      (pulse),
    .pulse_n_o    (pulse_n),
    .pulse_done_o (done)
  );

  // {a, b, clr_n, width, wait, expected pulse}
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 8'd5, 8'd4, 1'b0},  // R3 idle
    {1'b1, 1'b1, 1'b1, 8'd5, 8'd3, 1'b1},  // R1 rise A, B high
    {1'b1, 1'b1, 1'b1, 8'd5, 8'd4, 1'b1},  // R4 still high
    {1'b1, 1'b1, 1'b1, 8'd5, 8'd1, 1'b0},  // R4 ends after 5
    {1'b1, 1'b0, 1'b1, 8'd5, 8'd8, 1'b0},  // R8 B falls, A high
    {1'b0, 1'b0, 1'b1, 8'd5, 8'd6, 1'b0},  // R8 A falls
    {1'b1, 1'b0, 1'b1, 8'd5, 8'd6, 1'b0},  // R8 A rises, B low
    {1'b0, 1'b0, 1'b1, 8'd5, 8'd6, 1'b0},  // R8 A falls
    {1'b0, 1'b1, 1'b1, 8'd5, 8'd6, 1'b0},  // R8 B rises
    {1'b0, 1'b0, 1'b1, 8'd3, 8'd3, 1'b1},  // R2 B falls, A low
    {1'b0, 1'b0, 1'b1, 8'd3, 8'd2, 1'b1},  // R4
    {1'b0, 1'b0, 1'b1, 8'd3, 8'd1, 1'b0},  // R4 ends after 3
    {1'b0, 1'b1, 1'b1, 8'd0, 8'd6, 1'b0},  // R8 B rises
    {1'b0, 1'b0, 1'b1, 8'd0, 8'd8, 1'b0}   // R4 zero width
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; a = 1'b0; b = 1'b1; clr_n = 1'b1; w = 8'd5;
    wait_n(4);
    check("R3 pulse in reset", int'(pulse), 0);
    check("R3 pulse_n in reset", int'(pulse_n), 1);
    check("R3 done in reset", int'(done), 0);
    rst_n = 1'b1;
    wait_n(6);
    check("R3 pulse after reset", int'(pulse), 0);

    for (int i = 0; i < NV; i++) begin
      a = VEC[i][19]; b = VEC[i][18]; clr_n = VEC[i][17]; w = VEC[i][16:9];
      wait_n(int'(VEC[i][8:1]));
      check($sformatf("vector %0d pulse (R1 R2 R4 R8)", i), int'(pulse), int'(VEC[i][0]));
      check($sformatf("vector %0d complement R10", i), int'(pulse_n), int'(!VEC[i][0]));
    end

    // R4 width of one, R9 strobe
    b = 1'b1; w = 8'd1; wait_n(6);
    b = 1'b0; wait_n(3);
    check("R2 trigger width 1", int'(pulse), 1);
    wait_n(1);
    check("R4 width 1 ends", int'(pulse), 0);
    check("R9 done at timeout", int'(done), 1);
    wait_n(1);
    check("R9 done one cycle", int'(done), 0);

    // R5 retrigger
    b = 1'b1; w = 8'd6; wait_n(6);
    a = 1'b1; wait_n(3);
    check("R1 trigger before retrigger", int'(pulse), 1);
    hi = 1;
    a = 1'b0; wait_n(1);
    a = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (!pulse) break;
      hi++;
      wait_n(1);
    end
    check("R5 retriggered pulse length", hi, 10);
    check("R9 done after retriggered pulse", int'(done), 1);

    // R6 truncation by clear
    a = 1'b0; w = 8'd20; wait_n(6);
    a = 1'b1; wait_n(3);
    check("R1 pulse before clear", int'(pulse), 1);
    wait_n(3);
    clr_n = 1'b0; wait_n(2);
    check("R6 still high two edges after clear", int'(pulse), 1);
    wait_n(1);
    check("R6 cleared on third edge", int'(pulse), 0);
    check("R6 complement idle", int'(pulse_n), 1);
    check("R9 no done on clear", int'(done), 0);
    wait_n(1);
    check("R9 no done after clear", int'(done), 0);

    // R7 edges ignored during clear
    a = 1'b0; wait_n(4);
    a = 1'b1; wait_n(6);
    check("R7 A rise during clear", int'(pulse), 0);
    a = 1'b0; wait_n(4);
    b = 1'b0; wait_n(6);
    check("R7 B fall during clear", int'(pulse), 0);
    check("R7 complement during clear", int'(pulse_n), 1);

    // R11 edge during clear not stored
    b = 1'b1; wait_n(4);
    a = 1'b1; wait_n(1);
    clr_n = 1'b1; wait_n(8);
    check("R11 no pulse after release", int'(pulse), 0);
    a = 1'b0; wait_n(4);
    a = 1'b1; wait_n(3);
    check("R11 fresh edge triggers", int'(pulse), 1);
    wait_n(25);

    // R4 largest width
    a = 1'b0; w = 8'd255; wait_n(4);
    a = 1'b1; wait_n(3);
    hi = 0;
    for (int i = 0; i < 400; i++) begin
      if (!pulse) break;
      hi++;
      wait_n(1);
    end
    check("R4 max width length", hi, 255);
    check("R9 done after max width", int'(done), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule